// File: doc/BRIEF.md
# Event Interrupt Aggregator

This block gathers four single-cycle event pulses from neighbouring logic into one interrupt request line. Each event sets a sticky bit in a raw status register. A mask register selects which pending bits may reach the request line. The masked status is not stored: it is always the bitwise AND of the raw status and the mask. The request output is registered, so it follows the masked status one clock later.

Software reaches the block through a single-cycle register port. It can poll the raw status whatever the mask holds. It can inject events for diagnostics and retire them with write-one-to-clear. It can change individual mask bits through separate write-one-to-set and write-one-to-clear aliases, so no read-modify-write sequence is needed. The mask can also be loaded whole through a direct register. When a hardware event arrives in the same cycle that software clears the same bit, the bit stays set, so the event is not lost.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, the raw status, the mask and `irq_o` are all 0.
- R2: A 1 on `evt_i[n]` sets raw bit n at the next clock edge, and the bit stays set until it is cleared. The bit order is: bit 0 transmit-empty, bit 1 receive-full, bit 2 power-up, bit 3 power-down.
- R3: A read at 0x54 returns the raw status ANDed with the mask. A read at 0x4C returns the raw status. On every read, bits 31:4 are 0.
- R4: Writing to 0x5C sets each raw bit whose write-data bit is 1. Write-data bits that are 0 leave their raw bits unchanged.
- R5: Writing to 0x64 clears each raw bit whose write-data bit is 1. Write-data bits that are 0 leave their raw bits unchanged.
- R6: Writing 1s to 0x6C sets the matching mask bits. Writing 1s to 0x74 clears the matching mask bits. Write-data bits that are 0 leave their mask bits unchanged at either address.
- R7: Writing to 0x44 loads the mask with write data bits 3:0. A read at 0x44 returns the mask.
- R8: If an event pulse and a write-one-to-clear hit the same raw bit in the same cycle, the bit ends the cycle set.
- R9: `irq_o` equals the OR of all masked status bits as they stood one cycle earlier.
- R10: Reads at 0x5C, 0x64, 0x6C, 0x74 and at any unmapped address return 0. Writes to 0x4C and to 0x54 have no effect.
- R11: `rdata_o` is 0 whenever `re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe for this cycle |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable; read data is valid in the same cycle |
| rdata_o | output | 32 | Read data |
| evt_i | input | 4 | Event pulses, one bit per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle:
- a clear never wins over a same-cycle event or software set;
- raw bits that are set always stay set;
- the mask aliases act in the next cycle;
- `irq_o` trails the masked status by exactly one cycle;
- reserved read bits stay zero.

Other behaviours can only be shown by the bench's scenarios, driven against a behavioural model:
- writes of 0 to the set, clear and alias addresses are ignored;
- writes to the read-only status addresses are dropped;
- alias and unmapped addresses read as zero;
- `rdata_o` is quiet when `re_i` is low;
- a direct mask load keeps only its low four bits.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  parameter int NSRC   = 4;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 12;

  localparam logic [11:0] OFF_MASK = 12'h044;
  localparam logic [11:0] OFF_RAW  = 12'h04C;
  localparam logic [11:0] OFF_MIS  = 12'h054;
  localparam logic [11:0] OFF_SET  = 12'h05C;
  localparam logic [11:0] OFF_CLR  = 12'h064;
  localparam logic [11:0] OFF_MSET = 12'h06C;
  localparam logic [11:0] OFF_MCLR = 12'h074;

  typedef struct packed {
    logic mask_wr;
    logic set_wr;
    logic clr_wr;
    logic mset_wr;
    logic mclr_wr;
  } wr_strb_t;

  typedef enum logic [1:0] {RD_NONE, RD_MASK, RD_RAW, RD_MIS} rd_sel_e;
endpackage

// File: rtl/evt_irq_dec.sv
module evt_irq_dec
  import evt_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  output wr_strb_t      strb_o,
  output rd_sel_e       sel_o
);
  always_comb begin
    strb_o.mask_wr = we_i && (addr_i == AW'(OFF_MASK));
    strb_o.set_wr  = we_i && (addr_i == AW'(OFF_SET));
    strb_o.clr_wr  = we_i && (addr_i == AW'(OFF_CLR));
    strb_o.mset_wr = we_i && (addr_i == AW'(OFF_MSET));
    strb_o.mclr_wr = we_i && (addr_i == AW'(OFF_MCLR));
  end

  always_comb begin
    sel_o = RD_NONE;
    if (re_i) begin
      if (addr_i == AW'(OFF_MASK))     sel_o = RD_MASK;
      else if (addr_i == AW'(OFF_RAW)) sel_o = RD_RAW;
      else if (addr_i == AW'(OFF_MIS)) sel_o = RD_MIS;
    end
  end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] sset_i,
  input  logic [N-1:0] sclr_i,
  input  logic         mwr_i,
  input  logic [N-1:0] mwdata_i,
  input  logic [N-1:0] mset_i,
  input  logic [N-1:0] mclr_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] raw_q, mask_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // set paths take priority over clear so no event is dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     raw_q[g] <= 1'b0;
      else if (evt_i[g] || sset_i[g])  raw_q[g] <= 1'b1;
      else if (sclr_i[g])              raw_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mask_q[g] <= 1'b0;
      else if (mwr_i)      mask_q[g] <= mwdata_i[g];
      else if (mset_i[g])  mask_q[g] <= 1'b1;
      else if (mclr_i[g])  mask_q[g] <= 1'b0;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i | sset_i)) |=> ((raw_q & $past(evt_i | sset_i)) == $past(evt_i | sset_i)));

  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sclr_i & ~evt_i & ~sset_i)) |=> ((raw_q & $past(sclr_i & ~evt_i & ~sset_i)) == '0));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw_q & ~sclr_i)) |=> ((raw_q & $past(raw_q & ~sclr_i)) == $past(raw_q & ~sclr_i)));

  assert_mask_alias_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mwr_i && |mset_i) |=> ((mask_q & $past(mset_i)) == $past(mset_i)));
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int N  = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  evt_i,
  output logic          irq_o
);
  wr_strb_t     strb;
  rd_sel_e      sel;
  logic [N-1:0] wbits, raw, mask, mis;
  logic         irq_q;
  logic         unused_wdata;

  assign wbits        = wdata_i[N-1:0];
  assign unused_wdata = ^wdata_i[DW-1:N];

  evt_irq_dec #(.AW(AW)) dec_i (
    .addr_i (addr_i),
    .we_i   (we_i),
    .re_i   (re_i),
    .strb_o (strb),
    .sel_o  (sel)
  );

  evt_irq_bank #(.N(N)) bank_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .sset_i   (strb.set_wr  ? wbits : '0),
    .sclr_i   (strb.clr_wr  ? wbits : '0),
    .mwr_i    (strb.mask_wr),
    .mwdata_i (wbits),
    .mset_i   (strb.mset_wr ? wbits : '0),
    .mclr_i   (strb.mclr_wr ? wbits : '0),
    .raw_o    (raw),
    .mask_o   (mask)
  );

  assign mis = raw & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |mis;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      RD_MASK: rdata_o[N-1:0] = mask;
      RD_RAW:  rdata_o[N-1:0] = raw;
      RD_MIS:  rdata_o[N-1:0] = mis;
      default: rdata_o = '0;
    endcase
  end

  assert_irq_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(raw & mask))));

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:N] == '0);

  assert_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> (rdata_o == '0));
endmodule

// File: tb/evt_irq_agg_tb_top.sv
module evt_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  evt = '0;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  logic [3:0] raw_m = '0;
  logic [3:0] mask_m = '0;
  logic       irq_m = 1'b0;

  always #10 clk = ~clk;

  evt_irq_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [11:0] a, input logic r);
    if (!r) return '0;
    case (a)
      12'h044: return {28'h0, mask_m};
      12'h04C: return {28'h0, raw_m};
      12'h054: return {28'h0, raw_m & mask_m};
      default: return '0;
    endcase
  endfunction

  task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                     input logic r, input logic [3:0] e, input string tag);
    logic [3:0] s, c, ms, mc;
    @(negedge clk);
    chk({31'h0, irq}, {31'h0, irq_m}, "R9");
    addr = a; we = w; wdata = d; re = r; evt = e;
    #1;
    chk(rdata, model_rd(a, r), tag);
    @(posedge clk);
    s  = (w && a == 12'h05C) ? d[3:0] : 4'h0;
    c  = (w && a == 12'h064) ? d[3:0] : 4'h0;
    ms = (w && a == 12'h06C) ? d[3:0] : 4'h0;
    mc = (w && a == 12'h074) ? d[3:0] : 4'h0;
    irq_m = |(raw_m & mask_m);
    raw_m = e | s | (raw_m & ~c);
    if (w && a == 12'h044) mask_m = d[3:0];
    else                   mask_m = (mask_m | ms) & ~mc;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [11:0] amap [8];
    amap = '{12'h044, 12'h04C, 12'h054, 12'h05C, 12'h064, 12'h06C, 12'h074, 12'h100};
    re = 1'b1; addr = 12'h04C;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rdata, 32'h0, "R1 raw in reset");
    chk({31'h0, irq}, 32'h0, "R1 irq in reset");
    rst_n = 1'b1;
    cyc(12'h04C, 0, 0, 1, 4'h0, "R1 raw");
    cyc(12'h044, 0, 0, 1, 4'h0, "R1 mask");
    cyc(12'h000, 0, 0, 0, 4'h1, "R2 tx event");
    cyc(12'h04C, 0, 0, 1, 4'h0, "R2 raw tx");
    cyc(12'h04C, 0, 0, 1, 4'h8, "R2 pwrdn event");
    cyc(12'h04C, 0, 0, 1, 4'h0, "R2 raw hold");
    cyc(12'h054, 0, 0, 1, 4'h0, "R3 masked zero");
    cyc(12'h06C, 1, 32'h1, 0, 4'h0, "R6 mask set");
    cyc(12'h054, 0, 0, 1, 4'h0, "R3 masked tx");
    cyc(12'h074, 1, 32'h0, 0, 4'h0, "R6 zero clr");
    cyc(12'h044, 0, 0, 1, 4'h0, "R6 mask kept");
    cyc(12'h074, 1, 32'h1, 0, 4'h0, "R6 mask clr");
    cyc(12'h044, 0, 0, 1, 4'h0, "R6 mask gone");
    cyc(12'h044, 1, 32'hFFFF_FFF6, 0, 4'h0, "R7 load");
    cyc(12'h044, 0, 0, 1, 4'h0, "R7 readback");
    cyc(12'h05C, 1, 32'h6, 0, 4'h0, "R4 inject");
    cyc(12'h05C, 1, 32'h0, 1, 4'h0, "R4 zero inject");
    cyc(12'h04C, 0, 0, 1, 4'h0, "R4 raw");
    cyc(12'h064, 1, 32'h0, 0, 4'h0, "R5 zero clr");
    cyc(12'h04C, 0, 0, 1, 4'h0, "R5 raw kept");
    cyc(12'h064, 1, 32'hFFFF_FFF1, 0, 4'h0, "R5 clr");
    cyc(12'h064, 1, 32'h2, 0, 4'h2, "R8 collision");
    cyc(12'h04C, 0, 0, 1, 4'h0, "R8 raw kept");
    cyc(12'h064, 1, 32'hF, 0, 4'h0, "R5 clr all");
    cyc(12'h04C, 1, 32'hF, 0, 4'h0, "R10 raw write");
    cyc(12'h054, 1, 32'hF, 1, 4'h0, "R10 mis write");
    cyc(12'h04C, 0, 0, 1, 4'h0, "R10 raw zero");
    cyc(12'h05C, 1, 32'h4, 0, 4'h0, "R4 set pwrup");
    cyc(12'h05C, 0, 0, 1, 4'h0, "R10 set reads 0");
    cyc(12'h064, 0, 0, 1, 4'h0, "R10 clr reads 0");
    cyc(12'h06C, 0, 0, 1, 4'h0, "R10 mset reads 0");
    cyc(12'h074, 0, 0, 1, 4'h0, "R10 mclr reads 0");
    cyc(12'h100, 0, 0, 1, 4'h0, "R10 unmapped");
    cyc(12'h054, 0, 0, 0, 4'h0, "R11 re low");
    cyc(12'h054, 0, 0, 1, 4'h0, "R3 masked pwrup");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(amap[lfsr[2:0]], lfsr[3], {lfsr[15:8], 20'h0, lfsr[7:4]}, lfsr[9],
          (lfsr[12:10] == 3'd0) ? lfsr[7:4] : 4'h0, "R3 R9 random");
    end
    cyc(12'h000, 0, 0, 0, 4'h0, "R9 tail");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule